// File: doc/BRIEF.md
# Programmable-Priority DMA Channel Arbiter

This block decides which of five DMA channels gets the next bus transfer slot. Each channel can raise a request in two ways. It can hold a level request line from its peripheral, or software can pulse a trigger bit. A trigger pulse is kept as a pending flag until the channel's transfer completes. A channel takes part in arbitration only while its enable bit is high. Each channel also has a 2-bit priority register that software loads through a per-channel write strobe.

When no transfer is running, the arbiter compares the eligible channels. The highest priority level wins, and among equal levels the lowest channel index wins. The result is registered as a one-hot grant, a binary index and a valid flag. The grant stays fixed until the transfer engine pulses its done input. The arbiter then drops the grant and arbitrates again on the next edge.

Top module: `dma_prio_arb`

## Requirements
- R1: While `rst_ni` is low and after reset, the grant vector is zero and `grant_vld_o` is low. Every channel's priority is reset to low (0), so with no priority writes the lowest requesting index wins.
- R2: If an eligible hardware request is present while no grant is held, the grant appears on the first rising edge that sees it. `grant_o` is one-hot, with bit k set for channel k, and `grant_idx_o` equals k.
- R3: Priority encoding is 3 = very high, 2 = high, 1 = medium, 0 = low. Among eligible channels, the highest value wins.
- R4: Among eligible channels at the same highest level, the channel with the lowest index wins.
- R5: A channel whose `chan_en_i` bit is low is never granted, and a software trigger pulse on it is discarded.
- R6: A software trigger pulse on an enabled channel sets its pending flag on the next edge, so the grant is visible two edges after the pulse. The flag clears when `xfer_done_i` ends that channel's grant.
- R7: While a grant is held and `xfer_done_i` is low, `grant_o` and `grant_idx_o` do not change, whatever the requests, enables or priority writes.
- R8: `xfer_done_i` high while a grant is held clears the grant on that edge. The next arbitration happens on the following edge. `xfer_done_i` while no grant is held has no effect.
- R9: With no enabled channel requesting, `grant_o` is all zeros and `grant_vld_o` is low.
- R10: `prio_wr_i[k]` high loads `prio_wdata_i` into channel k's priority on that edge. A value written while a grant is held first counts at the next arbitration. A write on the arbitration edge itself counts from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | N_CH | Level request lines, one per channel |
| sw_trig_i | input | N_CH | Software trigger pulses, one per channel |
| chan_en_i | input | N_CH | Channel enable bits |
| prio_wr_i | input | N_CH | Priority write strobes, one per channel |
| prio_wdata_i | input | PRIO_W | Priority value to load |
| xfer_done_i | input | 1 | Transfer engine reports the granted transfer finished |
| grant_o | output | N_CH | One-hot grant |
| grant_idx_o | output | IDX_W | Index of the granted channel |
| grant_vld_o | output | 1 | A grant is held |

## Verification
A hardware request produces its grant one edge after the request is applied. A software trigger needs two edges, one to set the pending flag and one to arbitrate. A done pulse clears the grant on one edge, and the next grant can appear on the edge after that. A priority write counts from the first arbitration edge after the write edge. The bench drives inputs and samples outputs at the falling edge, and it counts exactly those edges before each directed comparison. A cycle-level model in the bench predicts the grant after every edge of the random phase.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    PRIO_LOW   = 2'd0,
    PRIO_MED   = 2'd1,
    PRIO_HIGH  = 2'd2,
    PRIO_VHIGH = 2'd3
  } prio_lvl_e;

  localparam logic [1:0] PRIO_RESET = PRIO_LOW;
endpackage

// File: rtl/dma_arb_prio_regs.sv
module dma_arb_prio_regs #(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned PRIO_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CH-1:0]               wr_i,
  input  logic [PRIO_W-1:0]             wdata_i,
  output logic [N_CH-1:0][PRIO_W-1:0]   prio_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      prio_o[c] <= PRIO_W'(dma_arb_pkg::PRIO_RESET);
      else if (wr_i[c]) prio_o[c] <= wdata_i;
    end
  end
endmodule

// File: rtl/dma_arb_pending.sv
module dma_arb_pending #(
  parameter int unsigned N_CH = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] sw_trig_i,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] pend_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   pend_o[c] <= 1'b0;
      else if (sw_trig_i[c] && en_i[c]) pend_o[c] <= 1'b1; // new trigger beats completion
      else if (clr_i[c])             pend_o[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select #(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_CH-1:0]             elig_i,
  input  logic [N_CH-1:0][PRIO_W-1:0] prio_i,
  output logic [N_CH-1:0]             win_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic                        any_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    any_o     = 1'b0;
    best      = '0;
    win_idx_o = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (elig_i[i] && (!any_o || prio_i[i] > best)) begin
        any_o     = 1'b1;
        best      = prio_i[i];
        win_idx_o = IDX_W'(i);
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_win
    assign win_o[c] = any_o && (win_idx_o == IDX_W'(c));
  end
endmodule

// File: rtl/dma_arb_grant.sv
module dma_arb_grant #(
  parameter int unsigned N_CH  = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [N_CH-1:0]  win_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             done_i,
  output logic [N_CH-1:0]  grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o,
  output logic [N_CH-1:0]  clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= '0;
      idx_o   <= '0;
      vld_o   <= 1'b0;
    end else if (vld_o) begin
      if (done_i) begin
        grant_o <= '0;
        idx_o   <= '0;
        vld_o   <= 1'b0;
      end
    end else if (any_i) begin
      grant_o <= win_i;
      idx_o   <= win_idx_i;
      vld_o   <= 1'b1;
    end
  end

  assign clr_o = (vld_o && done_i) ? grant_o : '0;
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   hw_req_i,
  input  logic [N_CH-1:0]   sw_trig_i,
  input  logic [N_CH-1:0]   chan_en_i,
  input  logic [N_CH-1:0]   prio_wr_i,
  input  logic [PRIO_W-1:0] prio_wdata_i,
  input  logic              xfer_done_i,
  output logic [N_CH-1:0]   grant_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              grant_vld_o
);
  logic [N_CH-1:0][PRIO_W-1:0] prio_q;
  logic [N_CH-1:0]             pend_q;
  logic [N_CH-1:0]             clr;
  logic [N_CH-1:0]             elig;
  logic [N_CH-1:0]             win;
  logic [IDX_W-1:0]            win_idx;
  logic                        win_any;

  dma_arb_prio_regs #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (prio_wr_i),
    .wdata_i (prio_wdata_i),
    .prio_o  (prio_q)
  );

  dma_arb_pending #(.N_CH(N_CH)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_trig_i (sw_trig_i),
    .en_i      (chan_en_i),
    .clr_i     (clr),
    .pend_o    (pend_q)
  );

  assign elig = chan_en_i & (hw_req_i | pend_q);

  dma_arb_select #(.N_CH(N_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .elig_i    (elig),
    .prio_i    (prio_q),
    .win_o     (win),
    .win_idx_o (win_idx),
    .any_o     (win_any)
  );

  dma_arb_grant #(.N_CH(N_CH), .IDX_W(IDX_W)) u_gnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_i     (win_any),
    .win_i     (win),
    .win_idx_i (win_idx),
    .done_i    (xfer_done_i),
    .grant_o   (grant_o),
    .idx_o     (grant_idx_o),
    .vld_o     (grant_vld_o),
    .clr_o     (clr)
  );
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned IDX_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  chan_en_i,
  input logic             xfer_done_i,
  input logic [N_CH-1:0]  grant_o,
  input logic [IDX_W-1:0] grant_idx_o,
  input logic             grant_vld_o
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R2
  grant_idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> (grant_o == (N_CH'(1) << grant_idx_o)));

  // R9
  grant_vld_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o == (grant_o != '0));

  // R5
  grant_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_vld_o) |-> ((grant_o & $past(chan_en_i)) != '0));

  // R7
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && !xfer_done_i) |=> ($stable(grant_o) && $stable(grant_idx_o)));

  // R8
  grant_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && xfer_done_i) |=> !grant_vld_o);
endmodule

bind dma_prio_arb dma_arb_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_en_i   (chan_en_i),
  .xfer_done_i (xfer_done_i),
  .grant_o     (grant_o),
  .grant_idx_o (grant_idx_o),
  .grant_vld_o (grant_vld_o)
);

// File: tb/dma_prio_arb_bench.sv
`timescale 1ns/1ps
module dma_prio_arb_bench;
  localparam int N  = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  hw_req = '0, sw_trig = '0, chan_en = '0, prio_wr = '0;
  logic [1:0]    prio_wdata = '0;
  logic          done = 1'b0;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;
  logic          grant_vld;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dma_prio_arb u_dma_prio_arb (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .sw_trig_i(sw_trig),
    .chan_en_i(chan_en), .prio_wr_i(prio_wr), .prio_wdata_i(prio_wdata),
    .xfer_done_i(done), .grant_o(grant), .grant_idx_o(grant_idx),
    .grant_vld_o(grant_vld)
  );

  // cycle model built from the requirements
  int           m_prio [N];
  logic [N-1:0] m_pend;
  logic         m_vld;
  int           m_idx;
  logic [N-1:0] m_clr, m_elig;
  int           m_win;

  function automatic int pick(input logic [N-1:0] elig);
    int w = -1;
    for (int i = 0; i < N; i++)
      if (elig[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_prio[i] = 0;
      m_pend = '0; m_vld = 1'b0; m_idx = 0;
    end else begin
      m_clr = '0;
      if (m_vld && done) m_clr[m_idx] = 1'b1;
      m_elig = chan_en & (hw_req | m_pend);
      if (m_vld) begin
        if (done) m_vld = 1'b0;
      end else begin
        m_win = pick(m_elig);
        if (m_win >= 0) begin m_vld = 1'b1; m_idx = m_win; end
      end
      m_pend = (m_pend & ~m_clr) | (sw_trig & chan_en);
      for (int i = 0; i < N; i++) if (prio_wr[i]) m_prio[i] = int'(prio_wdata);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_grant(input string tag, input bit vld, input int idx);
    chk(grant_vld == vld, tag, "valid", int'(grant_vld), int'(vld));
    if (vld) begin
      chk(int'(grant_idx) == idx, tag, "index", int'(grant_idx), idx);
      chk(grant == N'(1 << idx), tag, "grant", int'(grant), 1 << idx);
    end else begin
      chk(grant == '0, tag, "grant", int'(grant), 0);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_prio(input int ch, input int val);
    prio_wr = N'(1 << ch); prio_wdata = 2'(val);
    step(1);
    prio_wr = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd24680);
    step(2);
    // R1: outputs cleared under reset
    expect_grant("R1", 1'b0, 0);
    rst_n = 1'b1;
    step(1);
    expect_grant("R1", 1'b0, 0);

    // R1 default low priorities: tie resolved toward ch1 over ch3
    chan_en = '1;
    hw_req = 5'b01010;
    step(1);
    expect_grant("R1", 1'b1, 1);
    // R7: hold while requests change
    hw_req = 5'b11111;
    step(2);
    expect_grant("R7", 1'b1, 1);
    // R8: done clears on one edge, re-arbitration on the next
    hw_req = 5'b01000; done = 1'b1;
    step(1);
    done = 1'b0;
    expect_grant("R8", 1'b0, 0);
    step(1);
    expect_grant("R8", 1'b1, 3);
    done = 1'b1; hw_req = '0;
    step(1);
    done = 1'b0;
    // R9: no requests, no grant
    step(2);
    expect_grant("R9", 1'b0, 0);

    // R4: equal levels, lowest index
    hw_req = 5'b10100;
    step(1);
    expect_grant("R4", 1'b1, 2);
    hw_req = '0; done = 1'b1;
    step(1);
    done = 1'b0;

    // R3: higher level wins over lower index
    write_prio(4, 3);
    write_prio(0, 1);
    hw_req = 5'b10001;
    step(1);
    expect_grant("R3", 1'b1, 4);
    hw_req = '0; done = 1'b1;
    step(1);
    done = 1'b0;
    step(1);

    // R5: disabled channel ignores request and trigger
    chan_en = 5'b11110;
    hw_req = 5'b00001; sw_trig = 5'b00001;
    step(1);
    sw_trig = '0;
    step(2);
    expect_grant("R5", 1'b0, 0);
    hw_req = '0; chan_en = '1;
    step(2);
    expect_grant("R5", 1'b0, 0);

    // R6: trigger sets pending, grant two edges later, cleared by done
    sw_trig = 5'b01000;
    step(1);
    sw_trig = '0;
    expect_grant("R6", 1'b0, 0);
    step(1);
    expect_grant("R6", 1'b1, 3);
    done = 1'b1;
    step(1);
    done = 1'b0;
    step(2);
    expect_grant("R6", 1'b0, 0);

    // R10: writes during a grant count at the next arbitration
    write_prio(0, 0);
    write_prio(1, 0);
    hw_req = 5'b00001;
    step(1);
    expect_grant("R10", 1'b1, 0);
    hw_req = 5'b00011;
    write_prio(1, 2);
    write_prio(0, 3);
    expect_grant("R7", 1'b1, 0);
    done = 1'b1;
    step(1);
    done = 1'b0;
    step(1);
    expect_grant("R10", 1'b1, 0);
    hw_req = '0; done = 1'b1;
    step(1);
    done = 1'b0;

    // R8: done while idle has no effect on a later trigger
    sw_trig = 5'b00100;
    step(1);
    sw_trig = '0; hw_req = 5'b00000; done = 1'b1; chan_en = 5'b11011;
    step(1);
    done = 1'b0;
    expect_grant("R8", 1'b0, 0);
    chan_en = '1;
    step(1);
    expect_grant("R8", 1'b1, 2);
    done = 1'b1;
    step(1);
    done = 1'b0;

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      expect_grant("R2", m_vld, m_idx);
      for (int c = 0; c < N; c++) chan_en[c] = ($urandom % 8) != 0;
      hw_req  = N'($urandom & $urandom & $urandom);
      sw_trig = (($urandom % 6) == 0) ? N'(1 << ($urandom % N)) : '0;
      prio_wr = (($urandom % 5) == 0) ? N'(1 << ($urandom % N)) : '0;
      prio_wdata = 2'($urandom);
      done = ($urandom % 3) == 0;
      step(1);
    end
    expect_grant("R3", m_vld, m_idx);
    finish_run();
  end
endmodule